// File: doc/BRIEF.md
# Instruction-Decoded Serial Control Slave

This block is the serial control port of a power-management controller. A host talks to it over a four-wire serial bus in clock mode 0 or mode 3. Each frame opens with a one-byte opcode. Depending on the opcode, the slave then does one of three things: it takes a 16-bit control word, it returns that control word, or it returns an 8-bit fault byte supplied by the surrounding sensing logic. A write-permit flag must be set before a control-word write is accepted.

The stored control word drives a set of enables. These are one linear regulator enable, two load-switch enables, a switching regulator enable, a switching-rate select, a test-mode flag and a fault-scan start flag. All serial pins are oversampled by a faster system clock. The data output has a separate enable, so the pad is driven only while the host reads.

Top module: `pmSpiSlave`

## Requirements
- R1: After `rstN` is released, the control word is 0, the write-permit flag is clear, and `sdoOe` is 0.
- R2: Bits move MSB first. Input is sampled on rising serial-clock edges and output changes after falling edges, so the same frames work with the idle clock low (mode 0) or high (mode 3).
- R3: Opcode 0x06 sets the write-permit flag. With the flag set, a frame of opcode 0x02 followed by 16 data bits replaces the control word after its 24th rising edge. The flag stays set after the write.
- R4: Opcode 0x04 clears the write-permit flag. A 0x02 frame sent while the flag is clear leaves the control word unchanged.
- R5: The meaningful control-word bits are bit 15 (`linRegEn`), bit 14 (`load1En`), bit 13 (`load2En`), bit 10 (`fastClkSel`, 1 = higher switching rate), bit 9 (`swRegEn`), bit 1 (`testMode`) and bit 0 (`diagStart`). All other bits are stored as 0.
- R6: Writing bit 1 as 1 stores bits 15 down to 2 as 0, whatever was sent for them.
- R7: Opcode 0x03 returns the control word MSB first on the 16 clocks that follow the opcode.
- R8: Opcode 0x05 returns `diagIn`, captured as the opcode completes, MSB first on the 8 clocks after the opcode.
- R9: `sdoOe` is 1 only during the data bits of a read frame. It is 0 during the opcode bits and whenever chip select is high.
- R10: A chip select rising before the 24th edge of a write frame discards the partial data.
- R11: After 0x06 or 0x04 executes, further clocks in the same frame are ignored until chip select rises.
- R12: An unrecognised opcode changes neither the control word nor the write-permit flag.
- R13: A completed fault-byte read frame (all 16 clocks) clears `diagStart` (bit 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| diagIn | input | 8 | Fault byte returned by the 0x05 opcode |
| sdo | output | 1 | Serial data to the host |
| sdoOe | output | 1 | Output enable for the `sdo` pad |
| linRegEn | output | 1 | Linear regulator enable (bit 15) |
| load1En | output | 1 | First load-switch enable (bit 14) |
| load2En | output | 1 | Second load-switch enable (bit 13) |
| fastClkSel | output | 1 | Switching-rate select (bit 10) |
| swRegEn | output | 1 | Switching regulator enable (bit 9) |
| testMode | output | 1 | Test-mode flag (bit 1) |
| diagStart | output | 1 | Fault-scan start flag (bit 0) |

## Verification
Some properties are checked on every cycle:
- a stored test-mode bit always coexists with zeroed upper bits;
- the control word never moves while the write-permit flag is clear, except for the fault-read clear of bit 0;
- the opcode-completion strobes never fire together, and none fires in the wait state;
- a set-permit strobe is always followed by a set flag.

Other behaviour can only be shown by the bench's frames:
- MSB-first ordering in both clock modes;
- the 24-edge commit point;
- discarding of a cut-short write;
- clocks ignored after a permit opcode;
- unknown opcodes having no effect;
- output-enable timing.

// File: rtl/pmSpiPkg.sv
package pmSpiPkg;

  localparam int OP_BITS   = 8;
  localparam int WORD_BITS = 16;
  localparam int DIAG_BITS = 8;

  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_WEL_CLR = 8'h04;
  localparam logic [7:0] OP_WR_CTRL = 8'h02;
  localparam logic [7:0] OP_RD_DIAG = 8'h05;
  localparam logic [7:0] OP_RD_CTRL = 8'h03;

  // bits that hold state; all others read back as zero
  localparam logic [WORD_BITS-1:0] CTRL_MASK = 16'hE603;
  localparam int BIT_TEST = 1;
  localparam int BIT_DIAG = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_WR,
    ST_RD,
    ST_HOLD
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadCtrl;
    logic loadDiag;
    logic setWel;
    logic clrWel;
    logic commit;
    logic clrDiag;
    logic drive;
  } ctrlStrobe_t;

endpackage

// File: rtl/spiSync.sv
module spiSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic sdi,
  output logic sclkRise,
  output logic sclkFall,
  output logic csActive,
  output logic sdiS
);

  logic [STAGES-1:0] sclkPipe;
  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] sdiPipe;
  logic sclkLast;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          csPipe   <= '1;
          sdiPipe  <= '0;
        end else begin
          sclkPipe <= sclk;
          csPipe   <= csN;
          sdiPipe  <= sdi;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          csPipe   <= '1;
          sdiPipe  <= '0;
        end else begin
          sclkPipe <= {sclkPipe[STAGES-2:0], sclk};
          csPipe   <= {csPipe[STAGES-2:0], csN};
          sdiPipe  <= {sdiPipe[STAGES-2:0], sdi};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkLast <= 1'b0;
    else       sclkLast <= sclkPipe[STAGES-1];
  end

  assign sclkRise = sclkPipe[STAGES-1] & ~sclkLast;
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkLast;
  assign csActive = ~csPipe[STAGES-1];
  assign sdiS     = sdiPipe[STAGES-1];

endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import pmSpiPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        csActive,
  input  logic [7:0]  opcodeNext,
  output ctrlStrobe_t strobe
);

  localparam int LONG_FRAME  = OP_BITS + WORD_BITS;
  localparam int SHORT_FRAME = OP_BITS + DIAG_BITS;
  localparam int CNT_W       = $clog2(LONG_FRAME + 1);

  ctrlState_t state, stateN;
  logic [CNT_W-1:0] bitCnt, bitCntN;
  logic isDiag, isDiagN;
  logic [CNT_W-1:0] rdLast;

  assign rdLast = isDiag ? CNT_W'(SHORT_FRAME - 1) : CNT_W'(LONG_FRAME - 1);

  always_comb begin
    stateN  = state;
    bitCntN = bitCnt;
    isDiagN = isDiag;
    strobe  = '0;
    strobe.drive = (state == ST_RD) && csActive;
    if (!csActive) begin
      stateN  = ST_IDLE;
      bitCntN = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateN  = ST_OPC;
          bitCntN = '0;
        end
        ST_OPC: if (sclkRise) begin
          strobe.shiftIn = 1'b1;
          bitCntN = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(OP_BITS - 1)) begin
            unique case (opcodeNext)
              OP_WEL_SET: begin strobe.setWel = 1'b1; stateN = ST_HOLD; end
              OP_WEL_CLR: begin strobe.clrWel = 1'b1; stateN = ST_HOLD; end
              OP_WR_CTRL: stateN = ST_WR;
              OP_RD_CTRL: begin strobe.loadCtrl = 1'b1; isDiagN = 1'b0; stateN = ST_RD; end
              OP_RD_DIAG: begin strobe.loadDiag = 1'b1; isDiagN = 1'b1; stateN = ST_RD; end
              default:    stateN = ST_HOLD;
            endcase
          end
        end
        ST_WR: if (sclkRise) begin
          strobe.shiftIn = 1'b1;
          bitCntN = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(LONG_FRAME - 1)) begin
            strobe.commit = 1'b1;
            stateN = ST_HOLD;
          end
        end
        ST_RD: begin
          if (sclkRise) begin
            bitCntN = bitCnt + 1'b1;
            if (bitCnt == rdLast) begin
              strobe.clrDiag = isDiag;
              stateN = ST_HOLD;
            end
          end else if (sclkFall && bitCnt > CNT_W'(OP_BITS)) begin
            strobe.shiftOut = 1'b1;
          end
        end
        default: ; // ST_HOLD: wait for deselect
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isDiag <= 1'b0;
    end else begin
      state  <= stateN;
      bitCnt <= bitCntN;
      isDiag <= isDiagN;
    end
  end

  // R3: at most one opcode action per cycle
  a_r3_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setWel, strobe.clrWel, strobe.commit, strobe.loadCtrl, strobe.loadDiag}));

  // R11: nothing acts in the wait state
  a_r11_hold_inert: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> !(strobe.setWel | strobe.clrWel | strobe.commit |
                             strobe.loadCtrl | strobe.loadDiag | strobe.shiftOut));

endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import pmSpiPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic                 sdiS,
  input  logic [DIAG_BITS-1:0] diagIn,
  output logic [7:0]           opcodeNext,
  output logic [WORD_BITS-1:0] ctrlWord,
  output logic                 wel,
  output logic                 sdo,
  output logic                 sdoOe
);

  logic [WORD_BITS-1:0] inShift, outShift, rxNext, cleaned;

  assign rxNext     = {inShift[WORD_BITS-2:0], sdiS};
  assign opcodeNext = rxNext[7:0];

  always_comb begin
    cleaned = rxNext & CTRL_MASK;
    if (cleaned[BIT_TEST]) cleaned[WORD_BITS-1:2] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
      ctrlWord <= '0;
      wel      <= 1'b0;
    end else begin
      if (strobe.shiftIn) inShift <= rxNext;
      if (strobe.loadCtrl)      outShift <= ctrlWord;
      else if (strobe.loadDiag) outShift <= {diagIn, {(WORD_BITS-DIAG_BITS){1'b0}}};
      else if (strobe.shiftOut) outShift <= {outShift[WORD_BITS-2:0], 1'b0};
      if (strobe.setWel)      wel <= 1'b1;
      else if (strobe.clrWel) wel <= 1'b0;
      if (strobe.commit && wel) ctrlWord <= cleaned;
      else if (strobe.clrDiag)  ctrlWord[BIT_DIAG] <= 1'b0;
    end
  end

  assign sdoOe = strobe.drive;
  assign sdo   = strobe.drive & outShift[WORD_BITS-1];

  // R6: test mode never coexists with a set upper bit
  a_r6_test_clears_upper: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[BIT_TEST] |-> (ctrlWord[WORD_BITS-1:2] == '0));

  // R4: locked word does not move except the fault-read clear
  a_r4_locked_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!wel && !strobe.clrDiag) |=> $stable(ctrlWord));

  // R3: permit opcode always leaves the flag set
  a_r3_wel_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setWel |=> wel);

endmodule

// File: rtl/pmSpiSlave.sv
module pmSpiSlave
  import pmSpiPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       sdi,
  input  logic [7:0] diagIn,
  output logic       sdo,
  output logic       sdoOe,
  output logic       linRegEn,
  output logic       load1En,
  output logic       load2En,
  output logic       fastClkSel,
  output logic       swRegEn,
  output logic       testMode,
  output logic       diagStart
);

  logic sclkRise, sclkFall, csActive, sdiS, wel;
  logic [7:0] opcodeNext;
  logic [WORD_BITS-1:0] ctrlWord;
  ctrlStrobe_t strobe;

  spiSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csActive(csActive), .sdiS(sdiS)
  );

  spiCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csActive(csActive), .opcodeNext(opcodeNext), .strobe(strobe)
  );

  spiDatapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdiS(sdiS), .diagIn(diagIn),
    .opcodeNext(opcodeNext), .ctrlWord(ctrlWord), .wel(wel),
    .sdo(sdo), .sdoOe(sdoOe)
  );

  assign linRegEn   = ctrlWord[15];
  assign load1En    = ctrlWord[14];
  assign load2En    = ctrlWord[13];
  assign fastClkSel = ctrlWord[10];
  assign swRegEn    = ctrlWord[9];
  assign testMode   = ctrlWord[1];
  assign diagStart  = ctrlWord[0];

endmodule

// File: tb/sim_pmSpiSlave.sv
module sim_pmSpiSlave;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic [7:0] diagIn = 8'h00;
  logic sdo, sdoOe, linRegEn, load1En, load2En, fastClkSel, swRegEn, testMode, diagStart;

  int errors = 0;
  int checks = 0;
  localparam int HALF = 10;

  always #2 clk = ~clk;

  pmSpiSlave u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .diagIn(diagIn),
    .sdo(sdo), .sdoOe(sdoOe), .linRegEn(linRegEn), .load1En(load1En),
    .load2En(load2En), .fastClkSel(fastClkSel), .swRegEn(swRegEn),
    .testMode(testMode), .diagStart(diagStart)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] outWord();
    return {linRegEn, load1En, load2En, 2'b00, fastClkSel, swRegEn, 7'b0, testMode, diagStart};
  endfunction

  logic [23:0] rxBits;
  logic oeDuringOpc;

  // tx left-justified in 24 bits; nbits clocks are sent
  task automatic frame(input bit cpol, input int nbits, input logic [23:0] tx);
    sclk = cpol;
    waitClk(HALF);
    csN = 1'b0;
    rxBits = '0;
    oeDuringOpc = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (cpol) sclk = 1'b0;
      sdi = tx[23-i];
      waitClk(HALF);
      rxBits[23-i] = sdo;
      if (i < 8 && sdoOe) oeDuringOpc = 1'b1;
      sclk = 1'b1;
      waitClk(HALF);
      if (!cpol) sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
  endtask

  task automatic readCtrl(input bit cpol, output logic [15:0] val);
    frame(cpol, 24, {8'h03, 16'h0000});
    val = rxBits[15:0];
  endtask

  logic [15:0] rd;

  task automatic tResetState();
    check(outWord() == 16'h0000, "R1 reset word", 24'(outWord()), 0);
    check(sdoOe == 1'b0, "R1 sdoOe after reset", 24'(sdoOe), 0);
    readCtrl(1'b0, rd);
    check(rd == 16'h0000, "R1 read after reset", 24'(rd), 0);
  endtask

  task automatic tLockedWrite();
    frame(1'b0, 24, {8'h02, 16'hE600});
    check(outWord() == 16'h0000, "R4 write without permit", 24'(outWord()), 0);
  endtask

  task automatic tPermitWrite();
    frame(1'b0, 8, {8'h06, 16'h0});
    frame(1'b0, 24, {8'h02, 16'hFFFC});
    check(outWord() == 16'hE600, "R3 R5 write masks reserved", 24'(outWord()), 24'hE600);
    check(linRegEn && load1En && load2En && fastClkSel && swRegEn && !testMode,
          "R5 enable pins", 24'(outWord()), 24'hE600);
    readCtrl(1'b1, rd);
    check(rd == 16'hE600, "R7 R2 mode3 read", 24'(rd), 24'hE600);
    check(!oeDuringOpc, "R9 no drive in opcode", 24'(oeDuringOpc), 0);
    check(sdoOe == 1'b0, "R9 no drive deselected", 24'(sdoOe), 0);
    frame(1'b1, 24, {8'h02, 16'h0400});
    readCtrl(1'b0, rd);
    check(rd == 16'h0400, "R3 permit stays set, R2 mode0", 24'(rd), 24'h0400);
  endtask

  task automatic tClearPermit();
    frame(1'b0, 8, {8'h04, 16'h0});
    frame(1'b0, 24, {8'h02, 16'hE600});
    check(outWord() == 16'h0400, "R4 cleared permit blocks", 24'(outWord()), 24'h0400);
  endtask

  task automatic tTestMode();
    frame(1'b1, 8, {8'h06, 16'h0});
    frame(1'b1, 24, {8'h02, 16'hFFFF});
    check(outWord() == 16'h0003, "R6 test mode forces zeros", 24'(outWord()), 24'h0003);
    check(testMode && diagStart && !linRegEn, "R6 pins", 24'(outWord()), 24'h0003);
  endtask

  task automatic tDiagRead();
    diagIn = 8'hA5;
    frame(1'b1, 16, {8'h05, 16'h0});
    check(rxBits[15:8] == 8'hA5, "R8 fault byte mode3", 24'(rxBits[15:8]), 24'hA5);
    check(outWord() == 16'h0002, "R13 read clears start", 24'(outWord()), 24'h0002);
    diagIn = 8'h3C;
    frame(1'b0, 16, {8'h05, 16'h0});
    check(rxBits[15:8] == 8'h3C, "R8 fault byte mode0", 24'(rxBits[15:8]), 24'h3C);
  endtask

  task automatic tPartialWrite();
    frame(1'b0, 20, {8'h02, 16'hE600});
    check(outWord() == 16'h0002, "R10 partial write dropped", 24'(outWord()), 24'h0002);
  endtask

  task automatic tHoldAfterPermit();
    frame(1'b0, 16, {8'h06, 8'h04, 8'h0});
    frame(1'b0, 24, {8'h02, 16'h0200});
    check(outWord() == 16'h0200, "R11 clear ignored after set", 24'(outWord()), 24'h0200);
    frame(1'b0, 24, {8'h04, 8'h06, 8'h02});
    frame(1'b0, 24, {8'h02, 16'h8000});
    check(outWord() == 16'h0200, "R11 set ignored after clear", 24'(outWord()), 24'h0200);
  endtask

  task automatic tUnknownOp();
    frame(1'b0, 8, {8'h06, 16'h0});
    frame(1'b0, 24, {8'h42, 16'h8000});
    check(outWord() == 16'h0200, "R12 unknown keeps word", 24'(outWord()), 24'h0200);
    frame(1'b0, 24, {8'h02, 16'h8000});
    check(outWord() == 16'h8000, "R12 unknown keeps permit", 24'(outWord()), 24'h8000);
  endtask

  bit finished = 0;

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    tResetState();
    tLockedWrite();
    tPermitWrite();
    tClearPermit();
    tTestMode();
    tDiagRead();
    tPartialWrite();
    tHoldAfterPermit();
    tUnknownOp();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule